// File: doc/BRIEF.md
# Banked DCO Frequency-Locked Loop Controller

This block sets the control word of a digitally-controlled oscillator so that the oscillator runs at a chosen multiple of a 32.768 kHz crystal reference. It is clocked by the oscillator itself. It brings the reference into that domain through a short flop chain. It then counts oscillator cycles across a window of one or more reference periods and compares the count with a target. After each window it moves the control word by at most one fine step. The target is the wanted oscillator frequency divided by the reference frequency, times the window length. The oscillator is meant to cover roughly 8 MHz to 33.5 MHz.

The 19-bit control word has two parts. The upper 5 bits pick one of several overlapping frequency banks, and the lower 14 bits are a fine code inside that bank. Because the banks overlap, the mapping from word to frequency is deliberately not monotonic. When fine stepping runs into a bank edge, the controller moves to the neighbouring bank and reloads the fine code with a preset value that gives about the same frequency there. Fine stepping then carries on from that point.

At reset the upper 16 bits of the word come from a stored start-up value and the low 3 bits take a fixed default. The loop runs only while the crystal-present input is high and no standby is requested. In every other state the word is frozen, so after standby the loop resumes from the code it had already found.

Top module: `dco_fll_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `dco_code` equals `{start_code, 3'b100}` and `locked` is 0. Bank = `dco_code[18:14]`, fine = `dco_code[13:0]`.
- R2: While `xtal_ok` is 0 the loop stays idle: `dco_code` keeps its start-up value and `locked` stays 0, whatever the reference does.
- R3: The first synchronized rising edge of the reference after the loop becomes active starts the first window. Each later group of `win_refs` reference periods (a value of 0 counts as 1) closes a window whose measured value is the number of oscillator cycles in it. The code changes at most once per closed window.
- R4: With dead band D (default 2), a window count below `target_cnt - D` adds 1 to the fine code. A count above `target_cnt + D` subtracts 1. Any count within ±D, bounds included, leaves the code unchanged.
- R5: `locked` rises after LOCK_WINS (default 4) consecutive windows inside the dead band, and not earlier.
- R6: Any window outside the dead band, and any bank change, clears `locked` at once.
- R7: While `standby_req` is 1 the code is held and `locked` is 0. When standby ends, stepping resumes from the held code, not from the start-up value.
- R8: An up step taken with fine ≥ 15359 (the upper rollover point) and bank < 31 moves to bank+1 and loads fine = 4096.
- R9: A down step taken with fine ≤ 1024 (the lower rollover point) and bank > 0 moves to bank−1 and loads fine = 12287.
- R10: In bank 31 with fine at or above the upper point, an up step leaves the code unchanged. In bank 0 with fine at or below the lower point, a down step leaves the code unchanged. The word never wraps.
- R11: When it drives an oscillator whose cycles per reference period follow the control word, the loop settles with the window count inside the dead band and asserts `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; all state runs on it |
| rst_n | input | 1 | Active-low synchronous reset; loads the start-up code |
| ref_clk | input | 1 | Asynchronous 32.768 kHz crystal reference |
| xtal_ok | input | 1 | High when a crystal is present; the loop is enabled only then |
| standby_req | input | 1 | High requests standby; the loop freezes its code |
| win_refs | input | 3 | Reference periods per measurement window (0 treated as 1) |
| target_cnt | input | 16 | Wanted oscillator cycle count per window |
| start_code | input | 16 | Stored start-up value for the upper 16 code bits |
| dco_code | output | 19 | Control word: bank select in [18:14], fine code in [13:0] |
| locked | output | 1 | High after enough consecutive in-band windows |

## Verification
The embedded properties check on every cycle that the code moves only in the cycle after a closed window while the loop is active, and then by at most one fine step. They also check that a bank change always goes to the adjacent bank with the preset fine value, that an in-band window leaves the code alone, and that lock can rise only on an in-band window and drops on an out-of-band one or in standby. What those properties cannot show are the actual numbers. The bench's scenarios show them: the measured count across multi-period windows, the dead-band edges at exactly ±2, the exact landing codes at both rollovers and both saturation ends, resumption from a held code after standby, and convergence against a behavioural oscillator model.

// File: rtl/dco_fll_pkg.sv
package dco_fll_pkg;

   // Direction chosen for the fine code after a closed window
   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DN   = 2'b10
   } step_e;

endpackage

// File: rtl/fll_ref_window.sv
module fll_ref_window #(
   parameter int CNT_W       = 16,
   parameter int WIN_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ref_in,
   input  logic [WIN_W-1:0] win_refs,
   output logic             meas_vld,
   output logic [CNT_W-1:0] meas_cnt
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fll_ref_window: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] stg_q;
   logic                   prev_q;
   logic                   rise;
   logic                   armed_q;
   logic [WIN_W-1:0]       per_q;
   logic [WIN_W-1:0]       win_len;
   logic [CNT_W-1:0]       cyc_q;
   logic                   vld_q;
   logic [CNT_W-1:0]       cnt_q;

   // Synchronizer chain and rising-edge detect keep running in every state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         stg_q  <= {stg_q[SYNC_STAGES-2:0], ref_in};
         prev_q <= stg_q[SYNC_STAGES-1];
      end
   end

   assign rise    = stg_q[SYNC_STAGES-1] & ~prev_q;
   assign win_len = (win_refs == '0) ? WIN_W'(1) : win_refs;

   // Cycle counter: a start edge sets it to 1, the closing edge reads it
   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         armed_q <= 1'b0;
         per_q   <= '0;
         cyc_q   <= '0;
         vld_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         vld_q <= 1'b0;
         if (cyc_q != CNT_TOP) cyc_q <= cyc_q + 1'b1;
         if (rise) begin
            if (!armed_q) begin
               armed_q <= 1'b1;
               cyc_q   <= CNT_W'(1);
               per_q   <= '0;
            end else if (per_q + 1'b1 == win_len) begin
               vld_q <= 1'b1;
               cnt_q <= cyc_q;
               cyc_q <= CNT_W'(1);
               per_q <= '0;
            end else begin
               per_q <= per_q + 1'b1;
            end
         end
      end
   end

   assign meas_vld = vld_q;
   assign meas_cnt = cnt_q;

   AST_WINDOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      meas_vld |=> !meas_vld);                                            // R3
   AST_NO_WINDOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !meas_vld);                                             // R2

endmodule

// File: rtl/fll_code_stepper.sv
module fll_code_stepper
   import dco_fll_pkg::*;
#(
   parameter int CODE_W       = 19,
   parameter int BANK_W       = 5,
   parameter int START_W      = 16,
   parameter int STARTUP_TAIL = 4,
   parameter int FINE_LO      = 1024,
   parameter int FINE_HI      = 15359,
   parameter int JUMP_UP_FINE = 4096,
   parameter int JUMP_DN_FINE = 12287
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [START_W-1:0] start_code,
   input  logic               upd,
   input  step_e              dir,
   output logic [CODE_W-1:0]  code,
   output logic               jump
);

   localparam int FINE_W = CODE_W - BANK_W;
   localparam int TAIL_W = CODE_W - START_W;
   localparam logic [BANK_W-1:0] BANK_TOP = '1;
   localparam logic [BANK_W-1:0] BANK_BOT = '0;
   localparam logic [FINE_W-1:0] F_HI = FINE_W'(FINE_HI);
   localparam logic [FINE_W-1:0] F_LO = FINE_W'(FINE_LO);
   localparam logic [FINE_W-1:0] F_JU = FINE_W'(JUMP_UP_FINE);
   localparam logic [FINE_W-1:0] F_JD = FINE_W'(JUMP_DN_FINE);

   if (TAIL_W < 1) begin : g_bad_tail
      $error("fll_code_stepper: start-up value must be narrower than the code");
   end
   if (!(FINE_LO < JUMP_UP_FINE && JUMP_UP_FINE < FINE_HI &&
         FINE_LO < JUMP_DN_FINE && JUMP_DN_FINE < FINE_HI)) begin : g_bad_jump
      $error("fll_code_stepper: jump targets must lie strictly inside the rollover points");
   end
   if (FINE_HI >= (1 << FINE_W) || FINE_LO < 0) begin : g_bad_fine
      $error("fll_code_stepper: rollover points outside the fine field");
   end

   logic [BANK_W-1:0] bank_q;
   logic [FINE_W-1:0] fine_q;
   logic              jump_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {bank_q, fine_q} <= {start_code, TAIL_W'(STARTUP_TAIL)};
         jump_q           <= 1'b0;
      end else begin
         jump_q <= 1'b0;
         if (upd) begin
            unique case (dir)
               STEP_UP: begin
                  if (fine_q >= F_HI) begin
                     if (bank_q != BANK_TOP) begin
                        bank_q <= bank_q + 1'b1;
                        fine_q <= F_JU;
                        jump_q <= 1'b1;
                     end
                  end else begin
                     fine_q <= fine_q + 1'b1;
                  end
               end
               STEP_DN: begin
                  if (fine_q <= F_LO) begin
                     if (bank_q != BANK_BOT) begin
                        bank_q <= bank_q - 1'b1;
                        fine_q <= F_JD;
                        jump_q <= 1'b1;
                     end
                  end else begin
                     fine_q <= fine_q - 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign code = {bank_q, fine_q};
   assign jump = jump_q;

   AST_MOVE_ONLY_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(code));                                            // R3
   AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && dir == STEP_HOLD) |=> $stable(code));                       // R4
   AST_FINE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q == $past(bank_q)) |-> (fine_q == $past(fine_q) ||
                                     fine_q == FINE_W'($past(fine_q) + 1'b1) ||
                                     fine_q == FINE_W'($past(fine_q) - 1'b1)));   // R4
   AST_BANK_UP_LANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q == BANK_W'($past(bank_q) + 1'b1) && bank_q != BANK_BOT) |-> (fine_q == F_JU && jump)); // R8
   AST_BANK_DN_LANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q == BANK_W'($past(bank_q) - 1'b1) && bank_q != BANK_TOP) |-> (fine_q == F_JD && jump)); // R9
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bank_q == BANK_BOT && $past(bank_q) == BANK_TOP) &&
      !(bank_q == BANK_TOP && $past(bank_q) == BANK_BOT));                // R10

endmodule

// File: rtl/fll_lock_detect.sv
module fll_lock_detect #(
   parameter int LOCK_WINS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic upd,
   input  logic in_band,
   input  logic jump,
   output logic locked
);

   localparam int LC_W = $clog2(LOCK_WINS + 1);
   localparam logic [LC_W-1:0] LC_TOP = LC_W'(LOCK_WINS);

   if (LOCK_WINS < 1) begin : g_bad_lock
      $error("fll_lock_detect: LOCK_WINS must be at least 1");
   end

   logic [LC_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !active || jump) begin
         run_q <= '0;
      end else if (upd) begin
         if (!in_band)             run_q <= '0;
         else if (run_q != LC_TOP) run_q <= run_q + 1'b1;
      end
   end

   assign locked = (run_q == LC_TOP);

   AST_LOCK_RISE_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(upd && in_band));                           // R5
   AST_LOCK_DROP_OUT_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !in_band) |=> !locked);                                     // R6
   AST_LOCK_DROP_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      jump |=> !locked);                                                  // R6
   AST_STANDBY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !locked);                                               // R7

endmodule

// File: rtl/dco_fll_ctrl.sv
module dco_fll_ctrl
   import dco_fll_pkg::*;
#(
   parameter int CODE_W       = 19,
   parameter int BANK_W       = 5,
   parameter int START_W      = 16,
   parameter int STARTUP_TAIL = 4,
   parameter int CNT_W        = 16,
   parameter int WIN_W        = 3,
   parameter int SYNC_STAGES  = 2,
   parameter int DEADBAND     = 2,
   parameter int LOCK_WINS    = 4,
   parameter int FINE_LO      = 1024,
   parameter int FINE_HI      = 15359,
   parameter int JUMP_UP_FINE = 4096,
   parameter int JUMP_DN_FINE = 12287
) (
   input  logic               clk_osc,
   input  logic               rst_n,
   input  logic               ref_clk,
   input  logic               xtal_ok,
   input  logic               standby_req,
   input  logic [WIN_W-1:0]   win_refs,
   input  logic [CNT_W-1:0]   target_cnt,
   input  logic [START_W-1:0] start_code,
   output logic [CODE_W-1:0]  dco_code,
   output logic               locked
);

   localparam int CMP_W = CNT_W + 1;

   if (DEADBAND < 0 || DEADBAND >= (1 << (CNT_W - 1))) begin : g_bad_band
      $error("dco_fll_ctrl: DEADBAND out of range");
   end
   if (BANK_W < 1 || BANK_W >= CODE_W) begin : g_bad_bank
      $error("dco_fll_ctrl: BANK_W must leave room for a fine field");
   end

   logic             active;
   logic             meas_vld;
   logic [CNT_W-1:0] meas_cnt;
   logic [CMP_W-1:0] meas_x;
   logic [CMP_W-1:0] tgt_x;
   logic             too_slow;
   logic             too_fast;
   logic             in_band;
   logic             upd;
   logic             jump;
   step_e            dir;

   assign active = xtal_ok & ~standby_req;

   fll_ref_window #(
      .CNT_W       (CNT_W),
      .WIN_W       (WIN_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_window (
      .clk      (clk_osc),
      .rst_n    (rst_n),
      .active   (active),
      .ref_in   (ref_clk),
      .win_refs (win_refs),
      .meas_vld (meas_vld),
      .meas_cnt (meas_cnt)
   );

   assign meas_x = CMP_W'(meas_cnt);
   assign tgt_x  = CMP_W'(target_cnt);

   if (DEADBAND == 0) begin : g_exact
      assign too_slow = meas_x < tgt_x;
      assign too_fast = meas_x > tgt_x;
   end else begin : g_band
      assign too_slow = (meas_x + CMP_W'(DEADBAND)) < tgt_x;
      assign too_fast = meas_x > (tgt_x + CMP_W'(DEADBAND));
   end

   assign in_band = ~too_slow & ~too_fast;
   assign dir     = too_slow ? STEP_UP : (too_fast ? STEP_DN : STEP_HOLD);
   assign upd     = meas_vld & active;

   fll_code_stepper #(
      .CODE_W       (CODE_W),
      .BANK_W       (BANK_W),
      .START_W      (START_W),
      .STARTUP_TAIL (STARTUP_TAIL),
      .FINE_LO      (FINE_LO),
      .FINE_HI      (FINE_HI),
      .JUMP_UP_FINE (JUMP_UP_FINE),
      .JUMP_DN_FINE (JUMP_DN_FINE)
   ) u_stepper (
      .clk        (clk_osc),
      .rst_n      (rst_n),
      .start_code (start_code),
      .upd        (upd),
      .dir        (dir),
      .code       (dco_code),
      .jump       (jump)
   );

   fll_lock_detect #(
      .LOCK_WINS (LOCK_WINS)
   ) u_lock (
      .clk     (clk_osc),
      .rst_n   (rst_n),
      .active  (active),
      .upd     (upd),
      .in_band (in_band),
      .jump    (jump),
      .locked  (locked)
   );

   AST_IDLE_FROZEN: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !active |=> $stable(dco_code));                                     // R7
   AST_NO_XTAL_UNLOCKED: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !xtal_ok |=> !locked);                                              // R2

endmodule

// File: tb/dco_fll_ctrl_tb.sv
module dco_fll_ctrl_tb;

   logic        clk_osc = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_clk = 1'b0;
   logic        xtal_ok = 1'b0;
   logic        standby_req = 1'b1;
   logic [2:0]  win_refs = 3'd1;
   logic [15:0] target_cnt = 16'd150;
   logic [15:0] start_code = 16'd18944;
   logic [18:0] dco_code;
   logic        locked;

   int n_chk  = 0;
   int n_fail = 0;
   int ref_per = 100;
   bit closed_loop = 1'b0;
   bit done = 1'b0;

   always #10 clk_osc = ~clk_osc;   // 50 MHz

   dco_fll_ctrl u_dut (
      .clk_osc     (clk_osc),
      .rst_n       (rst_n),
      .ref_clk     (ref_clk),
      .xtal_ok     (xtal_ok),
      .standby_req (standby_req),
      .win_refs    (win_refs),
      .target_cnt  (target_cnt),
      .start_code  (start_code),
      .dco_code    (dco_code),
      .locked      (locked)
   );

   // Behavioural oscillator: cycles per reference period as a function of code
   function automatic int osc_ratio(input logic [18:0] c);
      return 64 + int'(c[13:0]) - 4096 + 40 * (int'(c[18:14]) - 9);
   endfunction

   initial begin
      forever begin
         int per;
         per = closed_loop ? osc_ratio(dco_code) : ref_per;
         ref_clk = 1'b1;
         repeat (per / 2) @(negedge clk_osc);
         ref_clk = 1'b0;
         repeat (per - per / 2) @(negedge clk_osc);
      end
   end

   task automatic check(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_code(input int bank, input int fine, input string tag);
      check(int'(dco_code[18:14]), bank, {tag, " bank"});
      check(int'(dco_code[13:0]), fine, {tag, " fine"});
   endtask

   task automatic do_reset(input logic [15:0] sc);
      rst_n = 1'b0;
      standby_req = 1'b1;
      start_code = sc;
      repeat (4) @(negedge clk_osc);
      rst_n = 1'b1;
      @(negedge clk_osc);
   endtask

   task automatic enable_loop();
      @(negedge ref_clk);
      repeat (2) @(negedge clk_osc);
      standby_req = 1'b0;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge ref_clk);
      repeat (8) @(negedge clk_osc);
   endtask

   task automatic t_reset_state();
      do_reset(16'd18944);
      check_code(9, 4100, "R1 reset value");
      check(int'(locked), 0, "R1 reset lock");
   endtask

   task automatic t_no_crystal();
      xtal_ok = 1'b0;
      target_cnt = 16'd150;
      standby_req = 1'b0;
      wait_edges(6);
      check_code(9, 4100, "R2 no crystal holds");
      check(int'(locked), 0, "R2 no crystal lock");
      standby_req = 1'b1;
      xtal_ok = 1'b1;
   endtask

   task automatic t_step_up();
      target_cnt = 16'd150;
      enable_loop();
      wait_edges(6);
      check_code(9, 4105, "R4 slow steps up");
      standby_req = 1'b1;
   endtask

   task automatic t_band_and_lock();
      target_cnt = 16'd102;
      enable_loop();
      wait_edges(4);
      check_code(9, 4105, "R4 edge of band holds");
      check(int'(locked), 0, "R5 no lock after 3 windows");
      wait_edges(1);
      check(int'(locked), 1, "R5 lock after 4 windows");
      target_cnt = 16'd103;
      wait_edges(1);
      check_code(9, 4106, "R4 just outside band steps up");
      check(int'(locked), 0, "R6 out-of-band clears lock");
   endtask

   task automatic t_standby();
      standby_req = 1'b1;
      wait_edges(5);
      check_code(9, 4106, "R7 standby holds code");
      check(int'(locked), 0, "R7 standby lock");
      enable_loop();
      wait_edges(3);
      check_code(9, 4108, "R7 resumes from held code");
      standby_req = 1'b1;
   endtask

   task automatic t_step_down();
      target_cnt = 16'd97;
      enable_loop();
      wait_edges(4);
      check_code(9, 4105, "R4 fast steps down");
      standby_req = 1'b1;
      target_cnt = 16'd98;
      enable_loop();
      wait_edges(4);
      check_code(9, 4105, "R4 lower band edge holds");
      standby_req = 1'b1;
   endtask

   task automatic t_long_window();
      win_refs = 3'd3;
      target_cnt = 16'd305;
      enable_loop();
      wait_edges(7);
      check_code(9, 4107, "R3 three-period windows");
      standby_req = 1'b1;
      win_refs = 3'd1;
   endtask

   task automatic t_roll_up();
      do_reset(16'd20351);
      target_cnt = 16'd150;
      enable_loop();
      wait_edges(5);
      check_code(10, 4096, "R8 jump to next bank");
      wait_edges(1);
      check_code(10, 4097, "R8 fine stepping resumes");
      standby_req = 1'b1;
   endtask

   task automatic t_roll_down();
      do_reset(16'd18560);
      target_cnt = 16'd50;
      enable_loop();
      wait_edges(6);
      check_code(8, 12287, "R9 jump to lower bank");
      wait_edges(1);
      check_code(8, 12286, "R9 fine stepping resumes");
      standby_req = 1'b1;
   endtask

   task automatic t_saturate();
      do_reset(16'd65407);
      target_cnt = 16'd150;
      enable_loop();
      wait_edges(6);
      check_code(31, 15359, "R10 top saturates");
      standby_req = 1'b1;
      do_reset(16'd128);
      target_cnt = 16'd50;
      enable_loop();
      wait_edges(8);
      check_code(0, 1024, "R10 bottom saturates");
      standby_req = 1'b1;
   endtask

   task automatic t_closed_loop();
      do_reset(16'd18944);
      target_cnt = 16'd74;
      closed_loop = 1'b1;
      enable_loop();
      wait_edges(24);
      check(int'(locked), 1, "R11 closed loop locks");
      check(int'(osc_ratio(dco_code) >= 72 && osc_ratio(dco_code) <= 76), 1,
            "R11 settled ratio inside band");
      standby_req = 1'b1;
      closed_loop = 1'b0;
   endtask

   initial begin
      t_reset_state();
      t_no_crystal();
      t_step_up();
      t_band_and_lock();
      t_standby();
      t_step_down();
      t_long_window();
      t_roll_up();
      t_roll_down();
      t_saturate();
      t_closed_loop();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk_osc);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule